// File: doc/BRIEF.md
# SPD EEPROM I2C target

This block is the serial-bus side of a 256-byte presence-detect memory on a memory module. It sits on a two-wire bus as a target and runs from a fast system clock that oversamples SCL and SDA. It pulls SDA low through an open-drain enable and never drives it high. The seven-bit target address is the fixed device-type code `1010` followed by three strap pins, so up to eight of these blocks can share one bus. The low half of the array holds module identification and timing data. The high half is free for user data. A load port fills the array directly for test.

A host writes by sending the device byte with R/W = 0, then one word-address byte, then data bytes. The data bytes are staged in a 16-byte page latch. A valid stop commits them to the array and starts a timed program cycle. During that cycle the block ignores starts and does not acknowledge its own address. A host reads in one of three ways: it sets the pointer with a write header and then issues a repeated start (random read), it reads from the current pointer (current-address read), or it keeps acknowledging bytes (sequential read). Both SCL and SDA pass through glitch filters. Each change on SDA is held back by a fixed delay after SCL falls, which keeps the bus data-hold time.

Top module: `spd_target`

## Requirements
- R1: During and after reset `sda_oe` is 0. While the block has no transfer in progress, it keeps SDA released.
- R2: The block acknowledges a device byte only when its upper seven bits equal `1010` followed by `sel_pins[2:0]` (bit 0 of the byte is R/W, 1 = read). With any other address it leaves the ACK slot released and stays silent until the next start.
- R3: When a byte is written to a word address and later read back by random read (write header, repeated start, read header), the read returns that byte.
- R4: Write data fills a 16-byte page. After each byte the low four bits of the pointer increment and wrap within the page, and the upper four bits stay fixed. Bytes outside the written slots keep their values.
- R5: A sequential read increments the pointer across the whole 256-byte space, including page boundaries, and wraps from 0xFF to 0x00.
- R6: A current-address read returns the byte at the address one past the last byte read.
- R7: A stop that ends a transfer carrying at least one data byte starts a program cycle of `PROG_CYC` clocks. During it the block acknowledges no address. After it ends, the block acknowledges normally.
- R8: A pulse on SDA shorter than `FILT_CYC` clocks while SCL is high creates no start or stop, and the transfer in progress completes unchanged.
- R9: `sda_oe` never changes while SCL is high. It changes only between `HOLD_CYC` and `HOLD_CYC+FILT_CYC+6` clocks after SCL falls at the pin.
- R10: While `wr_lock` is 1 at commit, write bytes are still acknowledged, but the array keeps its previous contents.
- R11: Bytes loaded through the `ld_*` port are returned by later reads at the same addresses.
- R12: When the host answers a read byte with NACK, the block stops driving SDA until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen at the pin |
| sda_i | input | 1 | Bus data as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| sel_pins | input | 3 | Strap bits forming the low address bits |
| wr_lock | input | 1 | 1 blocks array updates at commit |
| ld_we | input | 1 | Test load strobe |
| ld_addr | input | 8 | Test load address |
| ld_data | input | 8 | Test load data |

## Verification
The assertions take for granted that the host keeps SCL low for longer than the filter delay plus `HOLD_CYC`. They also assume that the host changes SDA only in the middle of the low phase, except when it makes a start or stop, and that it never makes a start or stop while the target holds SDA low. The bench drives every bit with a quarter-period of 40 clocks. It sets SDA 40 clocks after each falling SCL edge, well after the target's own output change. It injects only one two-clock SDA spike, under the four-clock filter length. Expected SDA levels come from a byte-array model in the bench and are compared on every clock of each SCL high phase.

// File: rtl/spd_pkg.sv
// Shared definitions for the presence-detect serial target.
// Assumes an 8-bit word-address byte on the bus.
package spd_pkg;
    // Fixed upper nibble of the seven-bit target address.
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    // Link-layer states of the byte protocol.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_MACK
    } link_st_t;
endpackage

// File: rtl/spd_deglitch.sv
// Two-flop synchroniser followed by a persistence filter.
// The output follows the input only after FILT_CYC consecutive
// differing samples. Resets to 1, the idle level of the bus.
module spd_deglitch #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [1:0]    sync;
    logic [CW-1:0] cnt;

    // Bring the pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], raw};
    end

    // Accept a new level only after it has persisted long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean <= 1'b1;
            cnt   <= '0;
        end else if (sync[1] == clean) begin
            cnt <= '0;
        end else if (cnt == CW'(FILT_CYC - 1)) begin
            clean <= sync[1];
            cnt   <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/spd_store.sv
// Byte array with a page latch. Write bytes are staged per slot and
// copied into the array on a commit pulse, unless the commit is
// blocked. A test load port writes the array directly.
// Assumes commit and staging never fall in the same cycle.
module spd_store #(
    parameter int AW = 8,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [7:0]    ld_data,
    input  logic          stg_we,
    input  logic [PW-1:0] stg_idx,
    input  logic [7:0]    stg_data,
    input  logic          commit,
    input  logic          commit_en,
    input  logic [AW-PW-1:0] page,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam int DEPTH = 1 << AW;
    localparam int SLOTS = 1 << PW;

    logic [7:0]       mem   [DEPTH];
    logic [7:0]       buf_d [SLOTS];
    logic [SLOTS-1:0] buf_v;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic       v_q;
        logic [7:0] d_q;
        // Valid flag of this slot: set on staging, cleared on commit.
        always_ff @(posedge clk) begin
            if (!rst_n)                                v_q <= 1'b0;
            else if (commit)                           v_q <= 1'b0;
            else if (stg_we && stg_idx == PW'(s))      v_q <= 1'b1;
        end
        // Data of this slot.
        always_ff @(posedge clk) begin
            if (stg_we && stg_idx == PW'(s)) d_q <= stg_data;
        end
        assign buf_v[s] = v_q;
        assign buf_d[s] = d_q;
    end

    // Array update from the load port and from a page commit.
    always_ff @(posedge clk) begin
        if (ld_we) mem[ld_addr] <= ld_data;
        if (commit && commit_en) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (buf_v[i]) mem[{page, PW'(i)}] <= buf_d[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spd_link.sv
// Bit and byte protocol engine of the target. It works on filtered
// SCL/SDA: detects start/stop, matches the address, moves the
// pointer, stages write bytes, serialises read bytes, delays SDA
// changes after SCL falls and times the program cycle.
// Assumes the SCL low phase is longer than HOLD_CYC.
module spd_link
    import spd_pkg::*;
#(
    parameter int AW       = 8,
    parameter int PW       = 4,
    parameter int HOLD_CYC = 20,
    parameter int PROG_CYC = 1000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_f,
    input  logic          sda_f,
    input  logic [2:0]    sel_pins,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] ptr,
    output logic          stg_we,
    output logic [PW-1:0] stg_idx,
    output logic [7:0]    stg_data,
    output logic          commit,
    output logic          sda_oe,
    output logic          busy,
    output logic          idle_o,
    output logic          stop_o
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam int BW = $clog2(PROG_CYC + 1);

    link_st_t      st;
    logic          scl_q, sda_q;
    logic [3:0]    bitcnt;
    logic [7:0]    sh, rbyte;
    logic          rd_mode, mack, pending, oe_want;
    logic [HW-1:0] hold_cnt;
    logic [BW-1:0] busy_cnt;
    logic          scl_rise, scl_fall, start_ev, stop_ev;

    // Previous filtered levels for edge and condition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) {scl_q, sda_q} <= 2'b11;
        else        {scl_q, sda_q} <= {scl_f, sda_f};
    end

    assign busy     = (busy_cnt != '0);
    assign scl_rise = scl_f & ~scl_q;
    assign scl_fall = ~scl_f & scl_q;
    assign start_ev = scl_f & scl_q & sda_q & ~sda_f & ~busy;
    assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
    assign idle_o   = (st == ST_IDLE);
    assign stop_o   = stop_ev;

    // Protocol state, shifter, pointer and write staging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; bitcnt <= '0; sh <= '0; rbyte <= '0; ptr <= '0;
            rd_mode <= 1'b0; mack <= 1'b1; pending <= 1'b0;
            stg_we <= 1'b0; stg_idx <= '0; stg_data <= '0;
        end else begin
            stg_we <= 1'b0;
            if (start_ev) begin
                st <= ST_DEV; bitcnt <= '0;
            end else if (stop_ev) begin
                st <= ST_IDLE; pending <= 1'b0;
            end else begin
                case (st)
                    ST_DEV, ST_ADDR, ST_WR: begin
                        if (scl_rise) begin
                            sh <= {sh[6:0], sda_f}; bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (st == ST_DEV) begin
                                if (sh[7:1] == {DEV_TYPE, sel_pins}) begin
                                    st <= ST_DEV_ACK; rd_mode <= sh[0];
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else if (st == ST_ADDR) begin
                                ptr <= AW'(sh); st <= ST_ADDR_ACK;
                            end else begin
                                stg_we <= 1'b1; stg_idx <= ptr[PW-1:0]; stg_data <= sh;
                                ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + PW'(1)};
                                pending <= 1'b1; st <= ST_WR_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK: if (scl_fall) begin
                        bitcnt <= '0;
                        if (rd_mode) begin st <= ST_RD; rbyte <= rd_data; end
                        else         st <= ST_ADDR;
                    end
                    ST_ADDR_ACK, ST_WR_ACK: if (scl_fall) begin
                        bitcnt <= '0; st <= ST_WR;
                    end
                    ST_RD: if (scl_fall) begin
                        if (bitcnt == 4'd7) begin st <= ST_MACK; ptr <= ptr + AW'(1); end
                        else                bitcnt <= bitcnt + 4'd1;
                    end
                    ST_MACK: begin
                        if (scl_rise) mack <= sda_f;
                        else if (scl_fall) begin
                            if (!mack) begin st <= ST_RD; bitcnt <= '0; rbyte <= rd_data; end
                            else       st <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Level the target wants on SDA in the current state.
    always_comb begin
        case (st)
            ST_DEV_ACK, ST_ADDR_ACK, ST_WR_ACK: oe_want = 1'b1;
            ST_RD:   oe_want = ~rbyte[3'd7 - bitcnt[2:0]];
            default: oe_want = 1'b0;
        endcase
    end

    // Apply SDA changes HOLD_CYC clocks after each SCL fall.
    always_ff @(posedge clk) begin
        if (!rst_n || st == ST_IDLE) begin
            sda_oe <= 1'b0; hold_cnt <= '0;
        end else if (scl_fall) begin
            hold_cnt <= HW'(HOLD_CYC);
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - HW'(1);
            if (hold_cnt == HW'(1)) sda_oe <= oe_want;
        end
    end

    // Program-cycle timer started by a stop that ends a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0; commit <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (stop_ev && pending) begin
                busy_cnt <= BW'(PROG_CYC); commit <= 1'b1;
            end else if (busy_cnt != '0) begin
                busy_cnt <= busy_cnt - BW'(1);
            end
        end
    end
endmodule

// File: rtl/spd_target.sv
// Top of the presence-detect serial target: filters both bus lines,
// runs the protocol engine and holds the byte array.
// Assumes an external pull-up on SDA and SCL driven only by the host.
module spd_target #(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 16,
    parameter int FILT_CYC   = 4,
    parameter int HOLD_CYC   = 20,
    parameter int PROG_CYC   = 1000000,
    localparam int AW = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic [2:0]    sel_pins,
    input  logic          wr_lock,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [7:0]    ld_data
);
    localparam int PW = $clog2(PAGE_BYTES);

    logic [1:0]    pins, flt;
    logic [AW-1:0] ptr;
    logic          stg_we, commit, busy, link_idle, stop_seen;
    logic [PW-1:0] stg_idx;
    logic [7:0]    stg_data, rd_data;
    logic          scl_flt;

    assign pins    = {sda_i, scl_i};
    assign scl_flt = flt[0];

    for (genvar g = 0; g < 2; g++) begin : g_flt
        spd_deglitch #(.FILT_CYC(FILT_CYC)) u_flt (
            .clk(clk), .rst_n(rst_n), .raw(pins[g]), .clean(flt[g])
        );
    end

    spd_link #(.AW(AW), .PW(PW), .HOLD_CYC(HOLD_CYC), .PROG_CYC(PROG_CYC)) u_link (
        .clk(clk), .rst_n(rst_n), .scl_f(flt[0]), .sda_f(flt[1]),
        .sel_pins(sel_pins), .rd_data(rd_data), .ptr(ptr),
        .stg_we(stg_we), .stg_idx(stg_idx), .stg_data(stg_data),
        .commit(commit), .sda_oe(sda_oe), .busy(busy),
        .idle_o(link_idle), .stop_o(stop_seen)
    );

    spd_store #(.AW(AW), .PW(PW)) u_store (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .stg_we(stg_we), .stg_idx(stg_idx), .stg_data(stg_data),
        .commit(commit), .commit_en(~wr_lock), .page(ptr[AW-1:PW]),
        .rd_addr(ptr), .rd_data(rd_data)
    );
endmodule

// File: rtl/spd_target_chk.sv
// Protocol checks on the target, bound to every instance.
module spd_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_f,
    input logic busy,
    input logic sda_oe,
    input logic idle,
    input logic stop_ev
);
    // R9: the output holds still through a filtered SCL high phase.
    a_r9_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f)) |-> $stable(sda_oe));

    // R7: no drive at all during the program cycle.
    a_r7_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R7: the engine stays idle while programming.
    a_r7_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> idle);

    // R7: programming only begins on a stop.
    a_r7_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_ev));

    // R1: an idle engine keeps SDA released.
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && $past(idle)) |-> !sda_oe);
endmodule

bind spd_target spd_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_flt), .busy(busy),
    .sda_oe(sda_oe), .idle(link_idle), .stop_ev(stop_seen)
);

// File: tb/spd_target_tb_top.sv
// Bench: behavioural host plus byte-array model; SDA compared every clock.
module spd_target_tb_top;
    localparam int Q    = 40;
    localparam int PROG = 3000;
    localparam int HOLD = 20;
    localparam int FILT = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1, g_low = 1'b0;
    logic [2:0] strap = 3'b101;
    logic       wp = 1'b0, ld_we = 1'b0;
    logic [7:0] ld_addr = '0, ld_data = '0;
    logic       sda_oe;
    logic       bus_sda, sda_in;

    assign bus_sda = m_sda & ~sda_oe;
    assign sda_in  = bus_sda & ~g_low;

    spd_target #(.FILT_CYC(FILT), .HOLD_CYC(HOLD), .PROG_CYC(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_in), .sda_oe(sda_oe),
        .sel_pins(strap), .wr_lock(wp), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    int         n_chk = 0, n_fail = 0;
    logic [7:0] ref_mem [256];
    logic [7:0] ref_ptr = '0;
    logic       exp_valid = 1'b0, exp_oe = 1'b0;
    string      exp_tag = "";
    int         since_fall = 0;
    logic       oe_prev = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, plus output-edge timing (R9).
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (exp_valid) check(sda_oe === exp_oe, exp_tag, int'(sda_oe), int'(exp_oe));
            if (sda_oe !== oe_prev)
                check(!m_scl && since_fall >= HOLD && since_fall <= HOLD + FILT + 6,
                      "R9 output edge timing", since_fall, HOLD);
        end
        oe_prev    = sda_oe;
        since_fall = m_scl ? 0 : since_fall + 1;
    end

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        waitq(Q); m_sda = 1'b1; waitq(Q); m_scl = 1'b1; waitq(Q); m_sda = 1'b0; waitq(Q); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        waitq(Q); m_sda = 1'b0; waitq(Q); m_scl = 1'b1; waitq(Q); m_sda = 1'b1; waitq(Q);
    endtask

    // One bit slot; eo is the expected target drive during SCL high.
    task automatic bit_slot(input logic b, input logic eo, input logic glitch,
                            input string tag, output logic got);
        waitq(Q); m_sda = b; waitq(Q);
        m_scl = 1'b1; exp_oe = eo; exp_tag = tag; exp_valid = 1'b1;
        waitq(Q / 2);
        if (glitch) begin g_low = 1'b1; waitq(2); g_low = 1'b0; waitq(Q / 2 - 2); end
        else waitq(Q / 2);
        got = bus_sda;
        waitq(Q);
        exp_valid = 1'b0; m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input logic exp_ack,
                             input logic glitch, input string tag);
        logic got;
        for (int i = 7; i >= 0; i--) bit_slot(d[i], 1'b0, glitch && i == 7, tag, got);
        bit_slot(1'b1, exp_ack, 1'b0, tag, got);
        check(got == !exp_ack, {tag, " ack level"}, int'(got), int'(!exp_ack));
    endtask

    task automatic recv_byte(input logic [7:0] e, input logic nack, input string tag);
        logic got;
        logic [7:0] rx = '0;
        for (int i = 7; i >= 0; i--) begin
            bit_slot(1'b1, ~e[i], 1'b0, tag, got);
            rx[i] = got;
        end
        check(rx == e, {tag, " read byte"}, int'(rx), int'(e));
        bit_slot(nack, 1'b0, 1'b0, tag, got);
    endtask

    function automatic logic [7:0] dev(input logic rd);
        return {4'b1010, strap, rd};
    endfunction

    task automatic wr_seq(input logic [7:0] a, input logic [7:0] d[$],
                          input logic glitch, input string tag);
        bus_start();
        send_byte(dev(1'b0), 1'b1, 1'b0, tag);
        send_byte(a, 1'b1, 1'b0, tag);
        foreach (d[i]) begin
            logic [7:0] wa = {a[7:4], 4'(a[3:0] + i)};
            send_byte(d[i], 1'b1, glitch && i == 0, tag);
            if (!wp) ref_mem[wa] = d[i];
            ref_ptr = {a[7:4], 4'(wa[3:0] + 1)};
        end
        bus_stop();
    endtask

    task automatic rd_seq(input logic [7:0] a, input int n, input logic tail, input string tag);
        logic got;
        bus_start();
        send_byte(dev(1'b0), 1'b1, 1'b0, tag);
        send_byte(a, 1'b1, 1'b0, tag);
        ref_ptr = a;
        bus_start();
        send_byte(dev(1'b1), 1'b1, 1'b0, tag);
        for (int i = 0; i < n; i++) begin
            recv_byte(ref_mem[ref_ptr], i == n - 1, tag);
            ref_ptr = ref_ptr + 8'd1;
        end
        if (tail) bit_slot(1'b1, 1'b0, 1'b0, "R12 released after host NACK", got);
        bus_stop();
    endtask

    task automatic wait_prog();
        waitq(PROG + 50);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] q[$];
        waitq(6);
        check(sda_oe == 1'b0, "R1 released in reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        waitq(4);
        check(sda_oe == 1'b0, "R1 released after reset", int'(sda_oe), 0);

        // R11: fill the array through the load port.
        for (int i = 0; i < 256; i++) begin
            ld_we = 1'b1; ld_addr = 8'(i); ld_data = 8'((i * 7 + 3) & 255);
            ref_mem[i] = ld_data;
            @(negedge clk);
        end
        ld_we = 1'b0;

        // R2: wrong strap bits get no acknowledge.
        bus_start();
        send_byte({4'b1010, 3'b000, 1'b0}, 1'b0, 1'b0, "R2 foreign address");
        bus_stop();

        // R11 / R2: preloaded byte read with matching address.
        rd_seq(8'h05, 1, 1'b0, "R11 preload readback");

        // R3: single byte write and random read.
        q = '{8'hC3};
        wr_seq(8'h22, q, 1'b0, "R3 byte write");
        wait_prog();
        rd_seq(8'h22, 1, 1'b0, "R3 random read");

        // R4: page write wraps 0x1F -> 0x10; 0x20 untouched.
        q = '{8'h11, 8'h22, 8'h33};
        wr_seq(8'h1E, q, 1'b0, "R4 page write");
        wait_prog();
        rd_seq(8'h1E, 3, 1'b0, "R4 page wrap readback");
        rd_seq(8'h10, 1, 1'b0, "R4 wrapped slot");

        // R5 / R12: sequential read across 0xFF -> 0x00, then NACK.
        rd_seq(8'hFE, 4, 1'b1, "R5 sequential wrap");

        // R6: current-address read continues at 0x02.
        bus_start();
        send_byte(dev(1'b1), 1'b1, 1'b0, "R6 current read");
        recv_byte(ref_mem[ref_ptr], 1'b1, "R6 current read");
        ref_ptr = ref_ptr + 8'd1;
        bus_stop();

        // R7: address refused during program cycle, accepted after.
        q = '{8'h99};
        wr_seq(8'h40, q, 1'b0, "R7 write before busy");
        bus_start();
        send_byte(dev(1'b0), 1'b0, 1'b0, "R7 busy refuses address");
        bus_stop();
        wait_prog();
        rd_seq(8'h40, 1, 1'b0, "R7 accepted after busy");

        // R10: locked writes are acknowledged but not stored.
        wp = 1'b1;
        q = '{8'h11};
        wr_seq(8'h50, q, 1'b0, "R10 locked write");
        wait_prog();
        wp = 1'b0;
        rd_seq(8'h50, 1, 1'b0, "R10 array unchanged");

        // R8: short SDA spike while SCL is high is ignored.
        q = '{8'hA5};
        wr_seq(8'h60, q, 1'b1, "R8 spike during write");
        wait_prog();
        rd_seq(8'h60, 1, 1'b0, "R8 data intact");

        waitq(10);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule